// File: doc/BRIEF.md
# ADC Start-up Configuration Sequencer

This block brings a delta-sigma ADC with a byte-serial control port into a known state after power-up. On a start pulse it waits a programmable number of clock cycles for the converter's oscillator to settle. It then sends the byte pattern that resynchronises the converter's serial port. Next it reads the configuration register, rewrites it with a new depth pointer field, and writes every channel-setup register in one burst. It ends by starting a self-offset calibration and holding the chip select until the converter pulls its data-out line low.

The sequencer does not shift bits itself. It hands one byte at a time to a serial transaction engine through a request/acknowledge handshake and receives the byte shifted in during that transfer. It also tells the engine when the chip select must be asserted. The setup register contents and the calibration timeout are parameters. The power-up wait count is an input.

Top module: `adc_init_seq`

## Requirements
- R1: After reset, `done`, `err`, `xf_sel` and `xf_req` are all 0.
- R2: After `start` is taken, no byte request is raised for at least `pwr_wait` cycles.
- R3: The first select window carries 16 bytes: 15 bytes of 0xFF followed by one byte of 0xFE.
- R4: The second select window carries the configuration read command 0x0B followed by three filler bytes of 0x00. The bytes returned on `xf_rdata` for the three fillers are kept as the configuration value, high byte first.
- R5: The third select window carries the write command 0x03 and then the kept configuration bytes. The high and low bytes are unchanged. The middle byte's upper nibble (bits 7:4, the depth pointer) is replaced by 2*NUM_CSR-1, and its lower nibble is kept.
- R6: The fourth select window carries the command 0x05 and then 3*NUM_CSR bytes. Setup register 0 goes first, each register most significant byte first, with no further command byte.
- R7: The fifth window carries 0x81. The select stays high after that byte until `sdo` is seen at 0. The select then drops and `done` rises on the next cycle.
- R8: If `sdo` stays at 1 for CAL_TIMEOUT cycles after the 0x81 byte is acknowledged, `err` and `done` are both set.
- R9: The select drops for at least one cycle between windows, so exactly five windows appear per sequence.
- R10: Once raised, `xf_req` stays high with `xf_wdata` unchanged until `xf_ack`. A request is only raised while `xf_sel` is high.
- R11: `done` and `err` hold until the next `start`, which clears them. A `start` while a sequence runs is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the sequence; taken only when idle |
| pwr_wait | input | PW_W | Power-up wait in clock cycles |
| sdo | input | 1 | Converter data-out line, watched for calibration completion |
| xf_sel | output | 1 | Chip select request to the engine, active high |
| xf_req | output | 1 | Byte transfer request |
| xf_wdata | output | 8 | Byte to shift out |
| xf_ack | input | 1 | Transfer complete, one-cycle pulse |
| xf_rdata | input | 8 | Byte shifted in, valid with `xf_ack` |
| done | output | 1 | Sequence finished (successfully or by timeout) |
| err | output | 1 | Calibration completion not seen in time |

## Verification
A wrong phase or byte counter shows at the ports as a byte stream that differs from the expected one. It appears within the same select window, at the first misplaced byte. It also shows as a wrong number of windows once `done` rises. A corrupted kept configuration value or depth pointer shows in the third window, a few bytes after the read. A faulty wait or timeout counter shows as a first request that comes too early, or as `done` and `err` rising at the wrong cycle relative to the 0x81 acknowledge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE, PH_PWAIT, PH_XFER, PH_GAP, PH_POLL
   } phase_t;

   typedef enum logic [2:0] {
      FR_SYNC, FR_RDCFG, FR_WRCFG, FR_CSR, FR_CAL
   } frame_t;

   localparam logic [7:0] CMD_CFG_RD  = 8'h0B;
   localparam logic [7:0] CMD_CFG_WR  = 8'h03;
   localparam logic [7:0] CMD_CSR_WR  = 8'h05;
   localparam logic [7:0] CMD_OFS_CAL = 8'h81;
   localparam logic [7:0] SYNC_FILL   = 8'hFF;
   localparam logic [7:0] SYNC_LAST   = 8'hFE;
   localparam int         SYNC_BYTES  = 16;
endpackage

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= load_val;
      else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_bytesrc.sv
module adc_seq_bytesrc
   import adc_seq_pkg::*;
#(
   parameter int                      NUM_CSR     = 2,
   parameter int                      IDXW        = 5,
   parameter logic [NUM_CSR*24-1:0]   SETUP_WORDS = '0
) (
   input  frame_t          frame,
   input  logic [IDXW-1:0] idx,
   input  logic [23:0]     cfg_kept,
   output logic [7:0]      byte_out
);
   localparam int          NBYTES = 3 * NUM_CSR;
   localparam logic [3:0]  DEPTH  = 4'(2 * NUM_CSR - 1);

   logic [7:0] csr_b [NBYTES];

   for (genvar k = 0; k < NUM_CSR; k++) begin : g_reg
      for (genvar j = 0; j < 3; j++) begin : g_byte
         assign csr_b[3*k + j] = SETUP_WORDS[24*k + 16 - 8*j +: 8];
      end
   end

   always_comb begin
      byte_out = 8'h00;
      unique case (frame)
         FR_SYNC:  byte_out = (idx == IDXW'(SYNC_BYTES - 1)) ? SYNC_LAST : SYNC_FILL;
         FR_RDCFG: byte_out = (idx == '0) ? CMD_CFG_RD : 8'h00;
         FR_WRCFG: begin
            case (idx)
               IDXW'(0): byte_out = CMD_CFG_WR;
               IDXW'(1): byte_out = cfg_kept[23:16];
               IDXW'(2): byte_out = {DEPTH, cfg_kept[11:8]};
               default:  byte_out = cfg_kept[7:0];
            endcase
         end
         FR_CSR: begin
            if (idx == '0)
               byte_out = CMD_CSR_WR;
            else
               for (int b = 0; b < NBYTES; b++)
                  if (idx == IDXW'(b + 1)) byte_out = csr_b[b];
         end
         FR_CAL:   byte_out = CMD_OFS_CAL;
         default:  byte_out = 8'h00;
      endcase
   end
endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq
   import adc_seq_pkg::*;
#(
   parameter int                    NUM_CSR     = 2,
   parameter logic [NUM_CSR*24-1:0] SETUP_WORDS = {24'h4C0105, 24'h000000},
   parameter int                    PW_W        = 24,
   parameter int                    CAL_TIMEOUT = 100000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [PW_W-1:0] pwr_wait,
   input  logic            sdo,
   output logic            xf_sel,
   output logic            xf_req,
   output logic [7:0]      xf_wdata,
   input  logic            xf_ack,
   input  logic [7:0]      xf_rdata,
   output logic            done,
   output logic            err
);
   localparam int LAST_MAX = (3 * NUM_CSR > SYNC_BYTES - 1) ? 3 * NUM_CSR : SYNC_BYTES - 1;
   localparam int IDXW     = $clog2(LAST_MAX + 1);
   localparam int TO_W     = $clog2(CAL_TIMEOUT + 1);

   if (NUM_CSR < 1 || NUM_CSR > 8) begin : g_bad_csr
      $error("NUM_CSR must lie in 1..8 so the depth pointer fits four bits");
   end
   if (PW_W < 1 || CAL_TIMEOUT < 1) begin : g_bad_cnt
      $error("PW_W and CAL_TIMEOUT must be positive");
   end

   phase_t          ph_q;
   frame_t          fr_q;
   logic [IDXW-1:0] idx_q;
   logic [IDXW-1:0] last_idx;
   logic [23:0]     cfg_q;
   logic            done_q, err_q;
   logic            pw_zero, to_zero;
   logic            byte_end, to_load;

   always_comb begin
      unique case (fr_q)
         FR_SYNC:  last_idx = IDXW'(SYNC_BYTES - 1);
         FR_RDCFG: last_idx = IDXW'(3);
         FR_WRCFG: last_idx = IDXW'(3);
         FR_CSR:   last_idx = IDXW'(3 * NUM_CSR);
         default:  last_idx = '0;
      endcase
   end

   assign byte_end = (ph_q == PH_XFER) && xf_ack;
   assign to_load  = byte_end && (fr_q == FR_CAL);

   adc_seq_cnt #(.W(PW_W)) u_pwr (
      .clk(clk), .rst_n(rst_n),
      .load(ph_q == PH_IDLE && start), .load_val(pwr_wait),
      .run(ph_q == PH_PWAIT), .zero(pw_zero)
   );

   adc_seq_cnt #(.W(TO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n),
      .load(to_load), .load_val(TO_W'(CAL_TIMEOUT)),
      .run(ph_q == PH_POLL), .zero(to_zero)
   );

   adc_seq_bytesrc #(
      .NUM_CSR(NUM_CSR), .IDXW(IDXW), .SETUP_WORDS(SETUP_WORDS)
   ) u_src (
      .frame(fr_q), .idx(idx_q), .cfg_kept(cfg_q), .byte_out(xf_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         fr_q   <= FR_SYNC;
         idx_q  <= '0;
         cfg_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start) begin
               ph_q   <= PH_PWAIT;
               done_q <= 1'b0;
               err_q  <= 1'b0;
            end
            PH_PWAIT: if (pw_zero) begin
               ph_q  <= PH_XFER;
               fr_q  <= FR_SYNC;
               idx_q <= '0;
            end
            PH_XFER: if (xf_ack) begin
               if (fr_q == FR_RDCFG) begin
                  case (idx_q)
                     IDXW'(1): cfg_q[23:16] <= xf_rdata;
                     IDXW'(2): cfg_q[15:8]  <= xf_rdata;
                     IDXW'(3): cfg_q[7:0]   <= xf_rdata;
                     default: ;
                  endcase
               end
               if (idx_q == last_idx) begin
                  idx_q <= '0;
                  if (fr_q == FR_CAL) begin
                     ph_q <= PH_POLL;
                  end else begin
                     ph_q <= PH_GAP;
                     fr_q <= frame_t'(fr_q + 3'd1);
                  end
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PH_GAP: ph_q <= PH_XFER;
            PH_POLL: begin
               if (!sdo) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end else if (to_zero) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign xf_req = (ph_q == PH_XFER);
   assign xf_sel = (ph_q == PH_XFER) || (ph_q == PH_POLL);
   assign done   = done_q;
   assign err    = err_q;
endmodule

// File: rtl/adc_init_seq_chk.sv
module adc_init_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       sdo,
   input logic       xf_sel,
   input logic       xf_req,
   input logic [7:0] xf_wdata,
   input logic       xf_ack,
   input logic       done,
   input logic       err
);
   p_req_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xf_req |-> xf_sel);

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xf_req && !xf_ack) |=> (xf_req && $stable(xf_wdata)));

   p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!xf_sel && !xf_req));

   p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   p_cal_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xf_sel && !xf_req && !sdo) |=> (!xf_sel && done && !err));
endmodule

bind adc_init_seq adc_init_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo),
   .xf_sel(xf_sel), .xf_req(xf_req), .xf_wdata(xf_wdata), .xf_ack(xf_ack),
   .done(done), .err(err)
);

// File: tb/sim_adc_init_seq.sv
module sim_adc_init_seq;
   localparam int TO = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] pwr_wait = 16'd0;
   logic        sdo = 1'b1;
   logic        xf_sel, xf_req, xf_ack = 1'b0;
   logic [7:0]  xf_wdata, xf_rdata = 8'h00;
   logic        done, err;

   int checks = 0, errors = 0;
   int cyc = 0;

   // engine model state
   logic [23:0] cfg_model = 24'h000000;
   bit          cal_hang = 1'b0;
   bit          cal_arm = 1'b0;
   bit          sel_prev = 1'b0;
   bit          sel_at_drop = 1'b0;
   int          eng_cnt = 0, pos = 0, frame = 0, nlog = 0, sdo_cnt = 0, stab_bad = 0;
   int          first_req_cyc = -1, cal_ack_cyc = 0, drop_cyc = 0;
   logic [7:0]  lat = 8'h00;
   logic [7:0]  logb [64];
   int          logf [64];

   always #4 clk = ~clk;

   adc_init_seq #(
      .NUM_CSR(2), .SETUP_WORDS({24'h4C0105, 24'h000000}),
      .PW_W(16), .CAL_TIMEOUT(TO)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pwr_wait(pwr_wait), .sdo(sdo),
      .xf_sel(xf_sel), .xf_req(xf_req), .xf_wdata(xf_wdata), .xf_ack(xf_ack),
      .xf_rdata(xf_rdata), .done(done), .err(err)
   );

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   // transaction engine and converter model, acts at falling edges
   initial forever begin
      @(negedge clk);
      xf_ack = 1'b0;
      if (xf_sel && !sel_prev) begin
         frame++;
         pos = 0;
      end
      sel_prev = xf_sel;
      if (xf_req) begin
         if (first_req_cyc < 0) first_req_cyc = cyc;
         if (eng_cnt == 0) lat = xf_wdata;
         else if (xf_wdata != lat) stab_bad++;
         eng_cnt++;
         if (eng_cnt == 3) begin
            if (nlog < 64) begin
               logb[nlog] = xf_wdata;
               logf[nlog] = frame;
               nlog++;
            end
            xf_rdata = (pos >= 1 && pos <= 3) ? cfg_model[(3 - pos) * 8 +: 8] : 8'h00;
            if (pos == 0 && xf_wdata == 8'h81) begin
               cal_ack_cyc = cyc;
               cal_arm = 1'b1;
               sdo_cnt = 0;
            end
            xf_ack = 1'b1;
            eng_cnt = 0;
            pos++;
         end
      end
      if (cal_arm && !cal_hang) begin
         sdo_cnt++;
         if (sdo_cnt == 10) begin
            sel_at_drop = xf_sel;
            drop_cyc = cyc;
            sdo = 1'b0;
            cal_arm = 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic clear_model();
      nlog = 0; frame = 0; first_req_cyc = -1; stab_bad = 0;
      cal_arm = 1'b0; sdo = 1'b1;
   endtask

   task automatic wait_done(output int at);
      at = -1;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) begin
            at = cyc;
            break;
         end
      end
   endtask

   task automatic test_reset();
      @(negedge clk);
      chk(done == 0 && err == 0, "R1 done/err", {done, err}, 0);
      chk(xf_sel == 0 && xf_req == 0, "R1 sel/req", {xf_sel, xf_req}, 0);
   endtask

   // full sequence with converter answering; also exercises start-while-busy
   task automatic test_full(input logic [15:0] pw, input logic [23:0] cfg, input bit poke);
      logic [7:0] exp [32];
      int start_cyc, at, n;
      clear_model();
      cfg_model = cfg;
      pwr_wait  = pw;
      n = 0;
      for (int i = 0; i < 15; i++) exp[n++] = 8'hFF;
      exp[n++] = 8'hFE;
      exp[n++] = 8'h0B; exp[n++] = 8'h00; exp[n++] = 8'h00; exp[n++] = 8'h00;
      exp[n++] = 8'h03; exp[n++] = cfg[23:16]; exp[n++] = {4'h3, cfg[11:8]}; exp[n++] = cfg[7:0];
      exp[n++] = 8'h05;
      exp[n++] = 8'h00; exp[n++] = 8'h00; exp[n++] = 8'h00;
      exp[n++] = 8'h4C; exp[n++] = 8'h01; exp[n++] = 8'h05;
      exp[n++] = 8'h81;
      @(negedge clk);
      start_cyc = cyc;
      pulse_start();
      chk(done == 0, "R11 start clears done", done, 0);
      if (poke) begin
         repeat (int'(pw) + 30) @(negedge clk);
         pulse_start();
      end
      wait_done(at);
      chk(at >= 0, "R7 done seen", at, 1);
      chk(first_req_cyc - start_cyc >= int'(pw), "R2 wait length", first_req_cyc - start_cyc, pw);
      chk(nlog == 32, "R9 byte count", nlog, 32);
      chk(frame == 5, "R9 window count", frame, 5);
      for (int i = 0; i < 32; i++) begin
         if (i < 16)      chk(logb[i] == exp[i] && logf[i] == 1, "R3 sync byte", logb[i], exp[i]);
         else if (i < 20) chk(logb[i] == exp[i] && logf[i] == 2, "R4 cfg read byte", logb[i], exp[i]);
         else if (i < 24) chk(logb[i] == exp[i] && logf[i] == 3, "R5 cfg write byte", logb[i], exp[i]);
         else if (i < 31) chk(logb[i] == exp[i] && logf[i] == 4, "R6 setup burst byte", logb[i], exp[i]);
         else             chk(logb[i] == exp[i] && logf[i] == 5, "R7 cal command", logb[i], exp[i]);
      end
      chk(sel_at_drop == 1'b1, "R7 select held until sdo low", sel_at_drop, 1);
      chk(at - drop_cyc <= 2, "R7 done latency", at - drop_cyc, 2);
      chk(err == 0, "R7 no error", err, 0);
      chk(stab_bad == 0, "R10 byte stable while pending", stab_bad, 0);
      sdo = 1'b1;
      repeat (20) @(negedge clk);
      chk(done == 1 && xf_sel == 0, "R11 done holds", {done, xf_sel}, 2);
   endtask

   task automatic test_timeout();
      int at;
      clear_model();
      cal_hang  = 1'b1;
      cfg_model = 24'h123456;
      pwr_wait  = 16'd5;
      pulse_start();
      wait_done(at);
      chk(err == 1 && done == 1, "R8 timeout flags", {err, done}, 3);
      chk(at - cal_ack_cyc >= TO, "R8 timeout not early", at - cal_ack_cyc, TO);
      chk(at - cal_ack_cyc <= TO + 3, "R8 timeout not late", at - cal_ack_cyc, TO + 3);
      repeat (10) @(negedge clk);
      chk(err == 1, "R11 err holds", err, 1);
      cal_hang = 1'b0;
      pulse_start();
      chk(err == 0 && done == 0, "R11 start clears err", {err, done}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_reset();
      test_full(16'd50, 24'hA5C63E, 1'b0);
      test_full(16'd7,  24'h0FFF81, 1'b1);
      test_timeout();
      repeat (2000) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule